// File: doc/BRIEF.md
# Dual Phase-Offset PWM Generator

This block drives two pulse-width-modulated outputs from one free-running 16-bit counter. The two outputs share the same period. Each output has its own high time. The second output's rising edge trails the first by a programmable number of counts. The counter is never reloaded. Instead, each channel keeps its own compare value. On each match, that value moves forward by either the high time or the low time, so every edge is placed relative to the previous edge of the same channel. All of this arithmetic wraps modulo 2^16.

Software loads a period, two widths and a delay on the input pins, then pulses `start`. On that edge the block captures and clamps the values. It seeds the channel-0 compare a small fixed offset ahead of the current count, and seeds channel 1 at that point plus the delay. Both outputs restart low. For every output edge, a one-cycle strobe marks whether the edge was rising or falling, which gives four events per period.

Top module: `dual_phase_pwm`

## Requirements
- R1: After reset, both outputs and all four strobes are low, and they stay low until the first `start`.
- R2: With the default offset of 4, channel 0 goes high on the 5th clock edge counted from the edge that samples `start` (that edge counts as the 1st).
- R3: Channel 1 goes high exactly D cycles after channel 0 goes high, where D is the captured delay.
- R4: Each channel stays high for exactly its captured width W cycles in every period.
- R5: Each channel repeats with period T cycles, so it stays low for T-W cycles between pulses.
- R6: A width of 0 is used as 1, and a width of T or more is used as T-1.
- R7: A delay above T is used as T. A delay of 0 makes the two rising edges coincide.
- R8: A period below 2 is used as 2.
- R9: Period, width and delay pins are sampled only on `start`, and changing them while running has no effect. A new `start` forces both outputs low in the next cycle and re-seeds both channels from the newly captured values.
- R10: A rise or fall strobe is high for exactly the one cycle in which its output has just gone high or low, and never at any other time.
- R11: Timing is unaffected when the counter wraps past 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture settings and (re)start both channels |
| period_in | input | 16 | Period T in counts |
| width0_in | input | 16 | High time of channel 0 |
| width1_in | input | 16 | High time of channel 1 |
| delay_in | input | 16 | Lag of channel 1 rising edge behind channel 0 |
| pwm0 | output | 1 | Channel 0 output |
| pwm1 | output | 1 | Channel 1 output |
| rise0 | output | 1 | Channel 0 rising-edge strobe |
| fall0 | output | 1 | Channel 0 falling-edge strobe |
| rise1 | output | 1 | Channel 1 rising-edge strobe |
| fall1 | output | 1 | Channel 1 falling-edge strobe |

## Verification
Every output is a register updated on the edge that follows a compare match. So after `start`, the expected level at cycle k is a closed-form function of k, the offset, T, W and D: the first rise of channel 0 appears at k = 5, and each later edge appears a whole number of W or T-W cycles after the previous one. The bench pulses `start`, counts falling clock edges from the edge that captured it, and compares every cycle against that formula. The strobes are checked in the same cycle as the output transition they mark. For the no-effect case, the pins are changed midway through a run and the waveform must keep matching the settings captured earlier.

// File: rtl/dpwm_pkg.sv
// Shared types and clamping helpers for the dual phase-offset PWM.
// Assumes a 16-bit counter; all compare arithmetic wraps modulo 2^16.
package dpwm_pkg;
    localparam int CNT_W = 16;
    typedef logic [CNT_W-1:0] cnt_t;

    // Period floor so that both phases of a channel are at least one count.
    function automatic cnt_t clamp_period(input cnt_t p);
        return (p < cnt_t'(2)) ? cnt_t'(2) : p;
    endfunction

    // Keep the width inside 1..T-1 so set and reset never share a count.
    function automatic cnt_t clamp_width(input cnt_t w, input cnt_t t);
        if (w == '0) return cnt_t'(1);
        if (w >= t)  return t - cnt_t'(1);
        return w;
    endfunction

    // Delay is limited to one full period.
    function automatic cnt_t clamp_delay(input cnt_t d, input cnt_t t);
        return (d > t) ? t : d;
    endfunction
endpackage

// File: rtl/dpwm_timebase.sv
// Free-running wrapping counter shared by both channels.
// Assumes nothing reloads it; it only wraps.
module dpwm_timebase
    import dpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output cnt_t cnt
);
    // Advance the shared count every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + cnt_t'(1);
    end

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt == cnt_t'($past(cnt) + cnt_t'(1))));
endmodule

// File: rtl/dpwm_cfg.sv
// Captures and clamps the period, widths and delay on start.
// Assumes start is a single-cycle request; settings are held until the next.
module dpwm_cfg
    import dpwm_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cnt_t              period_in,
    input  cnt_t [NUM_CH-1:0] width_in,
    input  cnt_t              delay_in,
    output cnt_t              delay_now,
    output cnt_t [NUM_CH-1:0] width_q,
    output cnt_t [NUM_CH-1:0] rest_q,
    output logic              run_q
);
    cnt_t period_c;
    cnt_t [NUM_CH-1:0] width_c;

    // Clamp the raw pins combinationally for capture and seeding.
    always_comb begin
        period_c  = clamp_period(period_in);
        delay_now = clamp_delay(delay_in, period_c);
        for (int i = 0; i < NUM_CH; i++) width_c[i] = clamp_width(width_in[i], period_c);
    end

    // Hold the captured settings and the running flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= '0;
            rest_q  <= '0;
            run_q   <= 1'b0;
        end else if (start) begin
            run_q <= 1'b1;
            for (int i = 0; i < NUM_CH; i++) begin
                width_q[i] <= width_c[i];
                rest_q[i]  <= period_c - width_c[i];
            end
        end
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(width_q) && $stable(rest_q)));

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_rng
            // R6
            width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                run_q |-> (width_q[g] != '0 && rest_q[g] != '0));
        end
    endgenerate
endmodule

// File: rtl/dpwm_channel.sv
// One PWM channel: a compare register and a phase bit. On a match the output
// takes the phase level, the phase flips, and the compare moves on by the width
// or by the rest of the period. Assumes width and rest are both nonzero.
module dpwm_channel
    import dpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  cnt_t cnt,
    input  cnt_t seed,
    input  cnt_t width,
    input  cnt_t rest,
    output logic pwm,
    output logic rise,
    output logic fall
);
    cnt_t cmp_q;
    logic set_next;
    logic hit;

    assign hit = run && (cnt == cmp_q);

    // Compare, phase and output update on start or on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q    <= '0;
            set_next <= 1'b1;
            pwm      <= 1'b0;
            rise     <= 1'b0;
            fall     <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (start) begin
                cmp_q    <= seed;
                set_next <= 1'b1;
                pwm      <= 1'b0;
            end else if (hit) begin
                pwm      <= set_next;
                rise     <= set_next;
                fall     <= ~set_next;
                set_next <= ~set_next;
                cmp_q    <= cmp_q + (set_next ? width : rest);
            end
        end
    end

    // R10
    rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (pwm && !$past(pwm)));
    // R10
    fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (!pwm && $past(pwm)));
    // R10
    pwm_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm != $past(pwm)) |-> (rise || fall || $past(start)));
    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pwm && !rise && !fall));
    // R9
    restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !pwm);
endmodule

// File: rtl/dual_phase_pwm.sv
// Top: two phase-offset PWM channels driven by one wrapping counter.
// Channel 0 is seeded INIT_OFS counts ahead of the counter at start; channel 1
// is seeded a further delay counts ahead. Assumes INIT_OFS >= 2 so the captured
// settings are in place before the first match.
module dual_phase_pwm
    import dpwm_pkg::*;
#(
    parameter int INIT_OFS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] period_in,
    input  logic [15:0] width0_in,
    input  logic [15:0] width1_in,
    input  logic [15:0] delay_in,
    output logic        pwm0,
    output logic        pwm1,
    output logic        rise0,
    output logic        fall0,
    output logic        rise1,
    output logic        fall1
);
    localparam int NUM_CH = 2;

    cnt_t cnt;
    cnt_t delay_now;
    logic run_q;
    cnt_t [NUM_CH-1:0] width_pins, width_q, rest_q, seed;
    logic [NUM_CH-1:0] pwm_v, rise_v, fall_v;

    assign width_pins[0] = width0_in;
    assign width_pins[1] = width1_in;

    // Channel seeds: fixed lead for channel 0, plus the delay for channel 1.
    always_comb begin
        seed[0] = cnt + cnt_t'(INIT_OFS);
        seed[1] = cnt + cnt_t'(INIT_OFS) + delay_now;
    end

    dpwm_timebase u_tb (.clk(clk), .rst_n(rst_n), .cnt(cnt));

    dpwm_cfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .start(start),
        .period_in(period_in), .width_in(width_pins), .delay_in(delay_in),
        .delay_now(delay_now), .width_q(width_q), .rest_q(rest_q), .run_q(run_q)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            dpwm_channel u_ch (
                .clk(clk), .rst_n(rst_n), .start(start), .run(run_q),
                .cnt(cnt), .seed(seed[g]), .width(width_q[g]), .rest(rest_q[g]),
                .pwm(pwm_v[g]), .rise(rise_v[g]), .fall(fall_v[g])
            );
        end
    endgenerate

    assign pwm0  = pwm_v[0];
    assign pwm1  = pwm_v[1];
    assign rise0 = rise_v[0];
    assign fall0 = fall_v[0];
    assign rise1 = rise_v[1];
    assign fall1 = fall_v[1];

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise0 && fall0) && !(rise1 && fall1));
endmodule

// File: tb/dual_phase_pwm_bench.sv
module dual_phase_pwm_bench;
    localparam int OFS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] period_in = '0, width0_in = '0, width1_in = '0, delay_in = '0;
    logic pwm0, pwm1, rise0, fall0, rise1, fall1;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    dual_phase_pwm u_dual_phase_pwm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .period_in(period_in), .width0_in(width0_in), .width1_in(width1_in),
        .delay_in(delay_in),
        .pwm0(pwm0), .pwm1(pwm1), .rise0(rise0), .fall0(fall0),
        .rise1(rise1), .fall1(fall1)
    );

    // Expected level k cycles after the start edge (k=1 is just after it).
    function automatic bit lvl(input int k, input int lag, input int t, input int w);
        int p;
        p = k - OFS - 1 - lag;
        if (p < 0) return 1'b0;
        return (p % t) < w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R1: nothing moves between reset and the first start.
    task automatic t_reset_idle();
        int bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm0 | pwm1 | rise0 | fall0 | rise1 | fall1) bad++;
        end
        check(bad == 0, "R1", "outputs idle after reset", bad, 0);
    endtask

    // Start with given pins, compare each cycle against the clamped expectation.
    task automatic run_case(input string req, input int t, input int w0, input int w1,
                            input int d, input int et, input int ew0, input int ew1,
                            input int ed, input int n, input bit perturb);
        int b0 = 0, b1 = 0, bs = 0, first0 = -1, first1 = -1;
        bit e0, e1, p0, p1;
        @(negedge clk);
        period_in = 16'(t); width0_in = 16'(w0); width1_in = 16'(w1); delay_in = 16'(d);
        start = 1'b1;
        p0 = 1'b0; p1 = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (perturb && k == n / 2) begin
                period_in = 16'd7; width0_in = 16'd3; width1_in = 16'd1; delay_in = 16'd2;
            end
            e0 = lvl(k, 0, et, ew0);
            e1 = lvl(k, ed, et, ew1);
            if (pwm0 !== e0) begin b0++; if (first0 < 0) first0 = k; end
            if (pwm1 !== e1) begin b1++; if (first1 < 0) first1 = k; end
            if (rise0 !== (e0 & ~p0) || fall0 !== (~e0 & p0) ||
                rise1 !== (e1 & ~p1) || fall1 !== (~e1 & p1)) bs++;
            p0 = e0; p1 = e1;
        end
        check(b0 == 0, req, $sformatf("ch0 level mismatches (first at k=%0d)", first0), b0, 0);
        check(b1 == 0, req, $sformatf("ch1 level mismatches (first at k=%0d)", first1), b1, 0);
        check(bs == 0, {req, " R10"}, "strobe mismatches", bs, 0);
    endtask

    // R2 R3: explicit first-edge timing after start.
    task automatic t_first_edges();
        int r0 = -1, r1 = -1;
        @(negedge clk);
        period_in = 16'd200; width0_in = 16'd50; width1_in = 16'd60; delay_in = 16'd33;
        start = 1'b1;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (rise0 && r0 < 0) r0 = k;
            if (rise1 && r1 < 0) r1 = k;
        end
        check(r0 == OFS + 1, "R2", "ch0 first rise cycle", r0, OFS + 1);
        check(r1 - r0 == 33, "R3", "ch1 rise lag", r1 - r0, 33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_first_edges();
        // R2 R3 R4 R5: scaled example, T=480, widths 2T/3 and T/4, delay T/6
        run_case("R2 R3 R4 R5", 480, 320, 120, 80, 480, 320, 120, 80, 1500, 1'b0);
        // R7: zero delay, edges coincide
        run_case("R7 zero delay", 100, 50, 30, 0, 100, 50, 30, 0, 400, 1'b0);
        // R7: delay of exactly T, and above T
        run_case("R7 delay=T", 100, 40, 70, 100, 100, 40, 70, 100, 500, 1'b0);
        run_case("R7 delay>T", 100, 40, 70, 150, 100, 40, 70, 100, 500, 1'b0);
        // R6: width 0 becomes 1, width >= T becomes T-1
        run_case("R6", 100, 0, 200, 10, 100, 1, 99, 10, 400, 1'b0);
        // R8: period 1 becomes 2 (widths then clamp to 1)
        run_case("R8", 1, 5, 0, 1, 2, 1, 1, 1, 100, 1'b0);
        // R9: pins changed mid-run are ignored
        run_case("R9 ignore", 300, 100, 200, 50, 300, 100, 200, 50, 1200, 1'b1);
        // R9: restart from a running state re-seeds with the new settings
        run_case("R9 restart", 7, 3, 1, 2, 7, 3, 1, 2, 200, 1'b0);
        // R11: run across counter wrap
        run_case("R11 wrap", 1000, 300, 700, 250, 1000, 300, 700, 250, 70000, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule